// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address for a short burst of up to four accesses from one start address that is presented once. A cycle with the load/advance control low and no stall captures an external address, together with the select and write qualifiers that come with it. Each later cycle with that control high and no stall moves the burst one step. The upper address bits are passed through from the captured address. The two low bits follow one of two orderings.

A static ordering input chooses between the orderings. With the input high, the low bits are the start value XOR a step count of 0 to 3. With the input low, the low bits are the start value plus the step count, modulo four. A stall input turns any cycle into a wait state: all captured state is held, and new address or control values are not taken in. The step count returns to zero after the fourth access, so a burst that keeps advancing repeats its sequence.

Top module: `burst_seq`

## Requirements
- R1: After reset, `addr_out` is zero, and `sel_out` and `wr_out` are both 0.
- R2: On a clock edge with `stall`=0 and `adv`=0, the block captures the inputs. From the next cycle, `addr_out` equals the captured `addr_in`, and `sel_out` and `wr_out` equal the captured `sel_in` and `wr_in`.
- R3: With `ilv_mode`=1, after k advancing edges since the last load, `addr_out[1:0]` equals the start low bits XOR (k mod 4).
- R4: With `ilv_mode`=0, after k advancing edges since the last load, `addr_out[1:0]` equals (start low bits + k) mod 4.
- R5: The fourth advancing edge after a load returns `addr_out[1:0]` to the start value. A fifth advancing edge gives the same value as the first one did.
- R6: On an edge with `stall`=1, no output changes, whatever the values of `adv`, `addr_in`, `sel_in` and `wr_in`.
- R7: An advancing edge (`stall`=0, `adv`=1) leaves `addr_out[ADDR_W-1:2]` unchanged.
- R8: On an advancing edge, `addr_in`, `sel_in` and `wr_in` are ignored, so `sel_out` and `wr_out` keep their captured values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| stall | input | 1 | 1 makes the cycle a wait state |
| adv | input | 1 | 0 loads a new start address, 1 advances the burst |
| ilv_mode | input | 1 | 1 selects XOR ordering, 0 selects wrap-around linear ordering |
| addr_in | input | ADDR_W | External start address |
| sel_in | input | 1 | Select qualifier captured at load |
| wr_in | input | 1 | Write qualifier captured at load |
| addr_out | output | ADDR_W | Current burst address |
| sel_out | output | 1 | Captured select qualifier |
| wr_out | output | 1 | Captured write qualifier |

## Verification
The assertions check the following on every cycle:
- a load takes in the presented address and qualifiers;
- a stall freezes every output;
- an advance leaves the upper bits and the qualifiers alone;
- a linear step adds one to the low bits, and an interleaved step from an even count flips only bit 0;
- the step count wraps from three to zero.

Only the bench's sweeps show the full sequence from every start value in both orderings, the repetition after the fourth access, and the way stalls placed in the middle of a burst interact with these.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  localparam int LOW_W = 2;
  typedef logic [LOW_W-1:0] low_t;

  // Low address bits for a given start value and step count.
  function automatic low_t map_low(input low_t start, input low_t offs, input logic ilv);
    low_t r;
    if (ilv) r = start ^ offs;
    else     r = low_t'(start + offs);
    return r;
  endfunction

  function automatic low_t step_offs(input low_t offs);
    return low_t'(offs + low_t'(1));
  endfunction
endpackage

// File: rtl/burst_ctrl_dec.sv
module burst_ctrl_dec (
  input  logic stall,
  input  logic adv,
  output logic do_load,
  output logic do_step
);
  always_comb begin
    do_load = !stall && !adv;
    do_step = !stall && adv;
  end
endmodule

// File: rtl/burst_offset_ctr.sv
module burst_offset_ctr
  import bseq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output low_t offs
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   offs <= '0;
    else if (clr) offs <= '0;
    else if (inc) offs <= step_offs(offs);
  end
endmodule

// File: rtl/burst_start_reg.sv
module burst_start_reg #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              sel_in,
  input  logic              wr_in,
  output logic [ADDR_W-1:0] base,
  output logic              sel_q,
  output logic              wr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base  <= '0;
      sel_q <= 1'b0;
      wr_q  <= 1'b0;
    end else if (cap) begin
      base  <= addr_in;
      sel_q <= sel_in;
      wr_q  <= wr_in;
    end
  end
endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import bseq_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall,
  input  logic              adv,
  input  logic              ilv_mode,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              sel_in,
  input  logic              wr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic              sel_out,
  output logic              wr_out
);
  localparam int UP_W = ADDR_W - LOW_W;

  logic              do_load;
  logic              do_step;
  low_t              offs;
  logic [ADDR_W-1:0] base;
  low_t              low_now;

  burst_ctrl_dec u_dec (
    .stall   (stall),
    .adv     (adv),
    .do_load (do_load),
    .do_step (do_step)
  );

  burst_offset_ctr u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (do_load),
    .inc   (do_step),
    .offs  (offs)
  );

  burst_start_reg #(.ADDR_W(ADDR_W)) u_start (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap     (do_load),
    .addr_in (addr_in),
    .sel_in  (sel_in),
    .wr_in   (wr_in),
    .base    (base),
    .sel_q   (sel_out),
    .wr_q    (wr_out)
  );

  assign low_now = map_low(base[LOW_W-1:0], offs, ilv_mode);

  generate
    if (UP_W > 0) begin : g_upper
      assign addr_out = {base[ADDR_W-1:LOW_W], low_now};
    end else begin : g_low_only
      assign addr_out = low_now[ADDR_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ilv_mode,
  input logic [ADDR_W-1:0] addr_in,
  input logic              sel_in,
  input logic              wr_in,
  input logic [ADDR_W-1:0] addr_out,
  input logic              sel_out,
  input logic              wr_out,
  input logic              do_load,
  input logic              do_step,
  input logic [1:0]        offs,
  input logic              stall
);
  // R2
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    do_load |=> (addr_out == $past(addr_in) && sel_out == $past(sel_in) && wr_out == $past(wr_in)));

  // R6
  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (ilv_mode != $past(ilv_mode) ||
               (addr_out == $past(addr_out) && sel_out == $past(sel_out) && wr_out == $past(wr_out))));

  // R7
  p_upper_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    do_step |=> (addr_out[ADDR_W-1:2] == $past(addr_out[ADDR_W-1:2])));

  // R8
  p_qual_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    do_step |=> ($stable(sel_out) && $stable(wr_out)));

  // R4
  p_linear_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (do_step && !ilv_mode) |=> (ilv_mode || addr_out[1:0] == 2'($past(addr_out[1:0]) + 2'd1)));

  // R3
  p_ilv_even_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (do_step && ilv_mode && !offs[0]) |=> (!ilv_mode || addr_out[1:0] == ($past(addr_out[1:0]) ^ 2'b01)));

  // R5
  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (do_step && offs == 2'd3) |=> (offs == 2'd0));

  // decode exclusivity
  p_dec_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(do_load && do_step));
endmodule

bind burst_seq burst_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ilv_mode (ilv_mode),
  .addr_in  (addr_in),
  .sel_in   (sel_in),
  .wr_in    (wr_in),
  .addr_out (addr_out),
  .sel_out  (sel_out),
  .wr_out   (wr_out),
  .do_load  (do_load),
  .do_step  (do_step),
  .offs     (offs),
  .stall    (stall)
);

// File: tb/burst_seq_test.sv
`timescale 1ns/1ps
module burst_seq_test;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          stall = 1'b0;
  logic          adv = 1'b0;
  logic          ilv_mode = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic          sel_in = 1'b0;
  logic          wr_in = 1'b0;
  logic [AW-1:0] addr_out;
  logic          sel_out;
  logic          wr_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // model state
  logic [AW-1:0] m_base;
  int            m_k;
  logic          m_sel, m_wr;

  always #2.5 clk = ~clk;

  burst_seq #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .stall(stall), .adv(adv), .ilv_mode(ilv_mode),
    .addr_in(addr_in), .sel_in(sel_in), .wr_in(wr_in),
    .addr_out(addr_out), .sel_out(sel_out), .wr_out(wr_out)
  );

  function automatic logic [AW-1:0] expect_addr(input logic [AW-1:0] b, input int k, input logic ilv);
    int s, lo;
    s = int'(b[1:0]);
    if (ilv) lo = s ^ (k % 4);
    else     lo = (s + k) % 4;
    return {b[AW-1:2], 2'(lo)};
  endfunction

  task automatic check_out(input string req);
    logic [AW-1:0] ea;
    ea = expect_addr(m_base, m_k, ilv_mode);
    checks++;
    if (addr_out !== ea || sel_out !== m_sel || wr_out !== m_wr) begin
      failures++;
      $display("FAIL %s: addr=%h sel=%b wr=%b expected addr=%h sel=%b wr=%b",
               req, addr_out, sel_out, wr_out, ea, m_sel, m_wr);
    end
  endtask

  task automatic cyc(input logic s, input logic a, input logic [AW-1:0] ad,
                     input logic si, input logic wi);
    stall = s; adv = a; addr_in = ad; sel_in = si; wr_in = wi;
    @(posedge clk);
    @(negedge clk);
    if (!s && !a) begin m_base = ad; m_k = 0; m_sel = si; m_wr = wi; end
    else if (!s && a) m_k = m_k + 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    m_base = '0; m_k = 0; m_sel = 1'b0; m_wr = 1'b0;
    repeat (3) @(negedge clk);
    check_out("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_out("R1");

    for (int md = 0; md < 2; md++) begin
      ilv_mode = md[0];
      for (int st = 0; st < 4; st++) begin
        for (int p = 0; p < 3; p++) begin
          logic [AW-1:0] a0;
          a0 = {14'(16'h1234 * (p + 1) + st * 97 + md * 5), 2'(st)};
          // stalled load attempt must not take effect
          cyc(1'b1, 1'b0, a0, 1'b1, 1'b1);
          check_out("R6");
          cyc(1'b0, 1'b0, a0, p[0], p[1]);
          check_out("R2");
          for (int k = 1; k <= 6; k++) begin
            if (p == 1 && k[0]) begin
              cyc(1'b1, 1'b1, ~a0, ~m_sel, ~m_wr);
              check_out("R6");
            end
            cyc(1'b0, 1'b1, ~a0, ~m_sel, ~m_wr);
            if (k == 4 || k == 5) check_out("R5");
            else if (md == 1) check_out("R3");
            else check_out("R4");
            checks++;
            if (addr_out[AW-1:2] !== a0[AW-1:2] || sel_out !== p[0] || wr_out !== p[1]) begin
              failures++;
              $display("FAIL R7/R8: upper=%h sel=%b wr=%b expected upper=%h sel=%b wr=%b",
                       addr_out[AW-1:2], sel_out, wr_out, a0[AW-1:2], p[0], p[1]);
            end
          end
        end
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule